// File: doc/BRIEF.md
# Strobe-to-Synchronous Transmit Adapter

This block sits between system logic that still speaks a strobe-and-acknowledge write protocol and a serial transmitter whose parallel port is clocked. Both sides run on the transmitter's reference clock, which runs at twice the character rate. The transmitter drives an active-low ready flag that toggles once per reference-clock cycle, so the flag itself works as a character-rate clock. The transmitter takes a character on a rising reference-clock edge only when the ready flag and the adapter's active-low write enable are both low.

The adapter watches the strobe level. In a cycle where the strobe is high and the ready flag is high, it registers the 12-bit combined bus and drives the write enable low for the next cycle, which is the cycle the transmitter will capture in. The bus is split into a data field and a command field according to a width-mode input. In narrow mode the split is 8 data bits and 4 command bits. In wide mode it is 10 data bits and 2 command bits. The two fields always add up to 12 bits. A data-or-command select is high whenever the command field is non-zero. An optional acknowledge pulse tells the system that the character has been taken.

A strobe held high is treated as a new request at every ready cycle. System logic must therefore drop the strobe after its last valid character, or that character is sent again. Because the bus is registered when the enable is armed, the system bus only needs to be valid around that arming edge.

Top module: `strobe_tx_adapter`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next cycle shows the write enable high (inactive), the acknowledge low, and the data, command and select outputs all zero.
- R2: The write enable is low in a cycle exactly when, at the preceding rising edge, the strobe was high and the ready flag was high. Otherwise it is high.
- R3: A character is captured at a rising edge where the ready flag and the write enable are both low. A strobe held high produces one capture per ready-low cycle, so each held cycle pair sends the character again.
- R4: In narrow mode (mode input 0), an arming edge loads the data output with bus bits [7:0] and bits [9:8] of the data output with zero. The command output is loaded with bus bits [11:8].
- R5: In wide mode (mode input 1), an arming edge loads the data output with bus bits [9:0]. Command output bits [1:0] are loaded with bus bits [11:10], and command output bits [3:2] are loaded with zero.
- R6: The select output is 1 (command character) when the loaded command field is non-zero, and 0 (data character) when it is all zero.
- R7: The data, command and select outputs keep their values across every edge that does not arm a capture.
- R8: The acknowledge is high for exactly one cycle: the cycle right after each capturing edge. It is low at all other times.
- R9: While the strobe is low, changes on the bus have no effect: no capture occurs and the outputs hold.
- R10: While the transmitter holds its ready flag high, no capture occurs even with the strobe held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock at twice the character rate |
| rst_i | input | 1 | Synchronous active-high reset |
| wide_mode_i | input | 1 | 0: 8-bit data and 4-bit command; 1: 10-bit data and 2-bit command |
| stb_i | input | 1 | Legacy write strobe, level-sampled on the reference clock |
| bus_i | input | 12 | Combined data and command bus from the system |
| ready_n_i | input | 1 | Active-low ready flag from the transmitter, toggling at character rate |
| wen_n_o | output | 1 | Active-low write enable to the transmitter |
| tx_data_o | output | 10 | Data field to the transmitter, zero-extended in narrow mode |
| tx_cmd_o | output | 4 | Command field to the transmitter, zero-extended in wide mode |
| tx_is_cmd_o | output | 1 | Select: 1 for a command character, 0 for a data character |
| ack_o | output | 1 | One-cycle acknowledge after each capture |

## Verification
Suppose the enable register armed on the wrong phase of the ready flag. The transmitter model would then record no capture where one was due, or a capture one cycle late, and the next acknowledge would be missing or displaced. Both show up within two reference-clock cycles of the strobe. A held character register that updated on a non-arming edge would show up at the very next capture as a mismatched field. A wrong mode split or a wrong command-zero decode would show up on the first character whose upper bus bits are non-zero. Held strobes and stalled ready flags are driven on purpose to expose duplicate or phantom captures.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int BUS_W     = 12;
  localparam int NARROW_DW = 8;
  localparam int WIDE_DW   = 10;
  localparam int CMD_NW    = BUS_W - NARROW_DW;
  localparam int CMD_WW    = BUS_W - WIDE_DW;

  typedef struct packed {
    logic [WIDE_DW-1:0] data;
    logic [CMD_NW-1:0]  cmd;
    logic               is_cmd;
  } tx_char_t;
endpackage

// File: rtl/stx_field_split.sv
module stx_field_split
  import stx_pkg::*;
(
  input  logic [BUS_W-1:0] bus_i,
  input  logic             wide_i,
  output tx_char_t         char_o
);
  logic [WIDE_DW-1:0] data_w;
  logic [CMD_NW-1:0]  cmd_w;

  for (genvar i = 0; i < WIDE_DW; i++) begin : g_data
    if (i < NARROW_DW) begin : g_common
      assign data_w[i] = bus_i[i];
    end else begin : g_wide_only
      assign data_w[i] = wide_i & bus_i[i];
    end
  end

  for (genvar j = 0; j < CMD_NW; j++) begin : g_cmd
    if (j < CMD_WW) begin : g_shared
      assign cmd_w[j] = wide_i ? bus_i[WIDE_DW+j] : bus_i[NARROW_DW+j];
    end else begin : g_narrow_only
      assign cmd_w[j] = ~wide_i & bus_i[NARROW_DW+j];
    end
  end

  always_comb begin
    char_o.data   = data_w;
    char_o.cmd    = cmd_w;
    char_o.is_cmd = |cmd_w;
  end
endmodule

// File: rtl/stx_arm_stage.sv
module stx_arm_stage
  import stx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     stb_i,
  input  logic     ready_n_i,
  input  tx_char_t next_i,
  output logic     wen_n_o,
  output tx_char_t char_o
);
  logic arm;
  assign arm = stb_i & ready_n_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wen_n_o <= 1'b1;
      char_o  <= '0;
    end else begin
      wen_n_o <= ~arm;
      if (arm) char_o <= next_i;
    end
  end

  AST_ENABLE_NEEDS_REQUEST: assert property (@(posedge clk_i) disable iff (rst_i)
    !wen_n_o |-> $past(stb_i && ready_n_i)); // R2
  AST_REQUEST_ENABLES: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(stb_i && ready_n_i) && !$past(rst_i)) |-> !wen_n_o); // R2
  AST_CHAR_HELD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(stb_i && ready_n_i) && !$past(rst_i)) |-> $stable(char_o)); // R7
endmodule

// File: rtl/stx_ack_gen.sv
module stx_ack_gen (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wen_n_i,
  input  logic ready_n_i,
  output logic ack_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) ack_o <= 1'b0;
    else       ack_o <= ~wen_n_i & ~ready_n_i;
  end

  AST_ACK_FOLLOWS_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |-> $past(!wen_n_i && !ready_n_i)); // R8
  AST_CAPTURE_GETS_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!wen_n_i && !ready_n_i) && !$past(rst_i)) |-> ack_o); // R8
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |=> !ack_o); // R8
endmodule

// File: rtl/strobe_tx_adapter.sv
module strobe_tx_adapter
  import stx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 wide_mode_i,
  input  logic                 stb_i,
  input  logic [BUS_W-1:0]     bus_i,
  input  logic                 ready_n_i,
  output logic                 wen_n_o,
  output logic [WIDE_DW-1:0]   tx_data_o,
  output logic [CMD_NW-1:0]    tx_cmd_o,
  output logic                 tx_is_cmd_o,
  output logic                 ack_o
);
  tx_char_t split_char;
  tx_char_t held_char;

  stx_field_split u_split (
    .bus_i  (bus_i),
    .wide_i (wide_mode_i),
    .char_o (split_char)
  );

  stx_arm_stage u_arm (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .stb_i     (stb_i),
    .ready_n_i (ready_n_i),
    .next_i    (split_char),
    .wen_n_o   (wen_n_o),
    .char_o    (held_char)
  );

  stx_ack_gen u_ack (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wen_n_i   (wen_n_o),
    .ready_n_i (ready_n_i),
    .ack_o     (ack_o)
  );

  assign tx_data_o   = held_char.data;
  assign tx_cmd_o    = held_char.cmd;
  assign tx_is_cmd_o = held_char.is_cmd;

  AST_SELECT_FROM_BUS: assert property (@(posedge clk_i) disable iff (rst_i)
    !wen_n_o |-> (tx_is_cmd_o == ($past(wide_mode_i) ? $past(|bus_i[BUS_W-1:WIDE_DW])
                                                     : $past(|bus_i[BUS_W-1:NARROW_DW])))); // R6
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wen_n_o && !$past(wide_mode_i)) |-> (tx_data_o[WIDE_DW-1:NARROW_DW] == '0)); // R4
  AST_WIDE_CMD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wen_n_o && $past(wide_mode_i)) |-> (tx_cmd_o[CMD_NW-1:CMD_WW] == '0)); // R5
endmodule

// File: tb/strobe_tx_adapter_test.sv
module strobe_tx_adapter_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, wide = 1'b0, stb = 1'b0, stall = 1'b0;
  logic [11:0] bus = '0;
  logic        ready_n = 1'b1;
  logic        wen_n, tx_is_cmd, ack;
  logic [9:0]  tx_data;
  logic [3:0]  tx_cmd;

  strobe_tx_adapter uut (
    .clk_i(clk), .rst_i(rst), .wide_mode_i(wide), .stb_i(stb), .bus_i(bus),
    .ready_n_i(ready_n), .wen_n_o(wen_n), .tx_data_o(tx_data), .tx_cmd_o(tx_cmd),
    .tx_is_cmd_o(tx_is_cmd), .ack_o(ack)
  );

  int checks = 0, fails = 0, cap_count = 0;
  bit done = 1'b0;

  // behavioural transmitter: ready flag toggles per cycle, captures on ready & enable low
  logic       cap_q = 1'b0, cap_sc = 1'b0;
  logic [9:0] cap_data = '0;
  logic [3:0] cap_cmd = '0;
  always @(posedge clk) begin
    cap_q <= !ready_n && !wen_n;
    if (!ready_n && !wen_n) begin
      cap_data  <= tx_data;
      cap_cmd   <= tx_cmd;
      cap_sc    <= tx_is_cmd;
      cap_count <= cap_count + 1;
    end
    ready_n <= (rst || stall) ? 1'b1 : ~ready_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench expectation state
  logic       d_rst = 1'b1, d_stb = 1'b0, d_wide = 1'b0, o_ready = 1'b1;
  logic [11:0] d_bus = '0;
  logic       e_wen = 1'b1, e_sc = 1'b0;
  logic [9:0] e_data = '0;
  logic [3:0] e_cmd = '0;

  task automatic step(input bit r, input bit s, input logic [11:0] b, input bit m, input bit st);
    logic       n_cap, armed;
    logic [9:0] o_data;
    logic [3:0] o_cmd;
    logic       o_sc;
    string      ftag;
    n_cap  = !e_wen && !o_ready;
    o_data = e_data; o_cmd = e_cmd; o_sc = e_sc;
    armed  = 1'b0;
    if (d_rst) begin
      n_cap = 1'b0; e_wen = 1'b1; e_data = '0; e_cmd = '0; e_sc = 1'b0;
    end else begin
      armed = d_stb && o_ready;
      e_wen = !armed;
      if (armed) begin
        e_data = d_wide ? d_bus[9:0] : {2'b00, d_bus[7:0]};
        e_cmd  = d_wide ? {2'b00, d_bus[11:10]} : d_bus[11:8];
        e_sc   = (e_cmd != 4'h0);
      end
    end
    ftag = d_rst ? "R1" : (!armed ? "R7" : (d_wide ? "R5" : "R4"));
    chk(cap_q == n_cap, "R3 capture", cap_q, n_cap);
    if (n_cap) begin
      chk(cap_data == o_data, "R3 captured data", cap_data, o_data);
      chk(cap_cmd == o_cmd, "R3 captured cmd", cap_cmd, o_cmd);
    end
    chk(ack == n_cap, d_rst ? "R1 ack" : "R8 ack", ack, n_cap);
    chk(wen_n == e_wen, d_rst ? "R1 enable" : "R2 enable", wen_n, e_wen);
    chk(tx_data == e_data, {ftag, " data"}, tx_data, e_data);
    chk(tx_cmd == e_cmd, {ftag, " cmd"}, tx_cmd, e_cmd);
    chk(tx_is_cmd == e_sc, d_rst ? "R1 select" : "R6 select", tx_is_cmd, e_sc);
    o_ready = ready_n;
    rst = r; stb = s; bus = b; wide = m; stall = st;
    d_rst = r; d_stb = s; d_bus = b; d_wide = m;
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed_v;
    int          c0;
    bit          m;
    seed_v = $urandom(32'd2024);
    @(negedge clk);
    for (int i = 0; i < 4; i++) step(1, 0, 12'h000, 0, 0);
    step(0, 0, 12'h000, 0, 0);
    // R1: explicit reset state
    chk(wen_n == 1'b1 && ack == 1'b0 && tx_data == 10'h0 && tx_cmd == 4'h0, "R1 reset state",
        {wen_n, ack, tx_data, tx_cmd}, {2'b10, 14'h0});
    // R3: held strobe sends again at each ready cycle
    c0 = cap_count;
    for (int i = 0; i < 12; i++) step(0, 1, 12'h3C5, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 12'h3C5, 0, 0);
    chk((cap_count - c0) >= 5 && (cap_count - c0) <= 6, "R3 held strobe repeats", cap_count - c0, 6);
    // R4/R5/R6 directed characters, each held long enough to hit a ready cycle
    for (int i = 0; i < 2; i++) step(0, 1, 12'h0FF, 0, 0);
    for (int i = 0; i < 2; i++) step(0, 1, 12'h100, 0, 0);
    for (int i = 0; i < 2; i++) step(0, 1, 12'h3FF, 1, 0);
    for (int i = 0; i < 2; i++) step(0, 1, 12'hC00, 1, 0);
    for (int i = 0; i < 2; i++) step(0, 1, 12'hA55, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 12'h000, 1, 0);
    // R9: bus activity with strobe low
    c0 = cap_count;
    for (int i = 0; i < 8; i++) step(0, 0, 12'($urandom), 0, 0);
    chk(cap_count == c0, "R9 idle bus no capture", cap_count - c0, 0);
    // R10: ready held high by the transmitter
    for (int i = 0; i < 3; i++) step(0, 0, 12'h000, 0, 1);
    c0 = cap_count;
    for (int i = 0; i < 6; i++) step(0, 1, 12'h5A5, 0, 1);
    chk(cap_count == c0, "R10 stalled ready no capture", cap_count - c0, 0);
    step(0, 0, 12'h000, 0, 0);
    step(0, 0, 12'h000, 0, 0);
    // constrained random traffic
    m = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (i % 250 == 0) m = ($urandom % 2) == 1;
      step(0, ($urandom % 3) != 0, 12'($urandom), m, ($urandom % 16) == 0);
    end
    step(0, 0, 12'h000, m, 0);
    step(0, 0, 12'h000, m, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule